// File: doc/BRIEF.md
# Seven-Operand Carry-Save Reduction Adder

This block adds seven unsigned 6-bit operands and returns a 9-bit total. The operands are not summed by a chain of word adders. All 42 input bits are treated as a matrix of dots arranged by weight, and four stages of 3:2 full-adder cells compress that matrix until no column holds more than two dots. A half-adder cell is placed in the last stage only, at the single column where the final adder needs it. One carry-propagate adder, 7 bits wide, then merges the two remaining rows.

The cell budget per stage is fixed at 12, 6, 6 and 4 full adders, with one half adder in the fourth stage. In total the tree uses 28 full adders and 1 half adder. The lowest result bit leaves the tree already resolved, so the carry-propagate adder covers weights 1 through 7, and its carry out becomes the top result bit.

A build-time switch selects the output form. The result can come straight from the adder logic, or it can pass through a register that also delays a valid strobe by one clock. That register takes a synchronous active-high reset.

Top module: `csa7_adder`

## Requirements
- R1: `sum_o` equals the exact arithmetic sum of the seven unsigned 6-bit operands. Its maximum is 441, so the 9-bit result never wraps.
- R2: Every full-adder cell maps three dots of weight w to a sum dot of weight w and a carry dot of weight 2w. The value of the three dots is preserved.
- R3: The only half-adder cell sits in the fourth stage at weight 64. It turns two dots into a sum dot of weight 64 and a carry dot of weight 128.
- R4: The four reduction stages hold 12, 6, 6 and 4 full adders, plus 1 half adder in the fourth stage.
- R5: Result bit 0 comes from the tree with no carry-propagate adder stage. It equals the XOR of bit 0 of all seven operands.
- R6: The final 7-bit carry-propagate adder spans weights 2 through 128. Its carry out is result bit 8, which is set whenever the total is 256 or more.
- R7: With `REG_OUT`=1, the result of the operands present before a rising clock edge appears at `sum_o` after that edge. The register loads on every cycle, so back-to-back operand sets give back-to-back results.
- R8: With `REG_OUT`=1, `out_valid_o` is `in_valid_i` delayed by exactly one clock. `in_valid_i` does not gate the result register.
- R9: With `REG_OUT`=1, a high `rst` at a rising edge clears `sum_o` to 0 and `out_valid_o` to 0. Both stay 0 for as long as `rst` remains high.
- R10: With `REG_OUT`=0, `sum_o` follows the operands combinationally, and `out_valid_o` equals `in_valid_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid_i | input | 1 | Strobe marking the operands as meaningful |
| operands_i | input | 42 | Seven 6-bit unsigned operands; operand k sits in bits 6k+5 down to 6k |
| sum_o | output | 9 | Sum of the seven operands |
| out_valid_o | output | 1 | Valid strobe aligned with `sum_o` |

## Verification
The cell-level checks assume that every operand bit is a defined 0 or 1 whenever the cells evaluate. The clocked checks on the output register assume the same for every sampling edge after reset. The bench never leaves an operand undriven or unknown: it drives all seven operands from time zero, and it changes them only at falling clock edges, well away from the edge that loads the register. The reference comparisons stay valid because the bench only uses operand values between 0 and 63 in each 6-bit field. Under that limit the tree total cannot exceed 441, so the 9-bit output never truncates.

// File: rtl/csa7_pkg.sv
package csa7_pkg;
  localparam int N_OPS = 7;
  localparam int OP_W  = 6;
  localparam int MAX_TOTAL = N_OPS * ((1 << OP_W) - 1);
  localparam int SUM_W = $clog2(MAX_TOTAL + 1);
  // bit 0 leaves the tree resolved; the CPA covers the remaining weights but the top one
  localparam int CPA_W = SUM_W - 2;

  typedef logic [N_OPS-1:0][OP_W-1:0] opvec_t;
  typedef logic [SUM_W-1:0]           sum_t;

  function automatic sum_t ref_total(input opvec_t v);
    sum_t acc;
    acc = '0;
    for (int k = 0; k < N_OPS; k++) acc = acc + sum_t'(v[k]);
    return acc;
  endfunction
endpackage

// File: rtl/csa7_fa.sv
module csa7_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a ^ b));
    // three dots in, weighted value preserved in {carry, sum}
    p_fa_count_r2: assert ({co, s} == 2'(a) + 2'(b) + 2'(ci))
      else $error("full adder cell lost weight");
  end
endmodule

// File: rtl/csa7_ha.sv
module csa7_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b;
    co = a & b;
    p_ha_count_r3: assert ({co, s} == 2'(a) + 2'(b))
      else $error("half adder cell lost weight");
  end
endmodule

// File: rtl/csa7_cpa.sv
module csa7_cpa #(
  parameter int W = 7
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   total
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa7_fa u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(carry[i]),
      .s (total[i]),
      .co(carry[i+1])
    );
  end

  assign total[W] = carry[W];
endmodule

// File: rtl/csa7_tree.sv
module csa7_tree
  import csa7_pkg::*;
(
  input  opvec_t operands,
  output sum_t   total
);
  // stage 1: two cells per column 0..5 (12 cells), operand 6 passes through
  logic [5:0] s1a, s1b, k1a, k1b;
  for (genvar c = 0; c < 6; c++) begin : g_st1
    csa7_fa u_lo (.a(operands[0][c]), .b(operands[1][c]), .ci(operands[2][c]),
                  .s(s1a[c]), .co(k1a[c]));
    csa7_fa u_hi (.a(operands[3][c]), .b(operands[4][c]), .ci(operands[5][c]),
                  .s(s1b[c]), .co(k1b[c]));
  end

  // stage 2: one cell per column 0..5 (6 cells) on the same-column dots
  logic [5:0] s2, k2;
  for (genvar c = 0; c < 6; c++) begin : g_st2
    csa7_fa u_fa (.a(operands[6][c]), .b(s1a[c]), .ci(s1b[c]),
                  .s(s2[c]), .co(k2[c]));
  end

  // stage 3: one cell per column 1..6 (6 cells) on the stage-1 carries
  logic [6:1] s3, k3;
  for (genvar c = 1; c < 7; c++) begin : g_st3
    if (c == 6) begin : g_top
      csa7_fa u_fa (.a(k1a[5]), .b(k1b[5]), .ci(k2[5]), .s(s3[c]), .co(k3[c]));
    end else begin : g_mid
      csa7_fa u_fa (.a(k1a[c-1]), .b(k1b[c-1]), .ci(s2[c]), .s(s3[c]), .co(k3[c]));
    end
  end

  // stage 4: cells on columns 2..5 (4 cells) plus a half adder on column 6
  logic [5:2] s4, k4;
  logic       s4h, k4h;
  for (genvar c = 2; c < 6; c++) begin : g_st4
    csa7_fa u_fa (.a(k2[c-1]), .b(s3[c]), .ci(k3[c-1]), .s(s4[c]), .co(k4[c]));
  end
  csa7_ha u_ha6 (.a(s3[6]), .b(k3[5]), .s(s4h), .co(k4h));

  // two rows over columns 1..7, column 0 already holds one dot
  logic [CPA_W-1:0] row_a, row_b;
  logic [CPA_W:0]   cpa_out;
  assign row_a = {k3[6], s4h,   s4[5], s4[4], s4[3], s4[2], k2[0]};
  assign row_b = {k4h,   k4[5], k4[4], k4[3], k4[2], 1'b0,  s3[1]};

  csa7_cpa #(.W(CPA_W)) u_cpa (
    .a    (row_a),
    .b    (row_b),
    .total(cpa_out)
  );

  assign total = {cpa_out, s2[0]};
endmodule

// File: rtl/csa7_adder.sv
module csa7_adder
  import csa7_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid_i,
  input  logic [N_OPS*OP_W-1:0]       operands_i,
  output logic [SUM_W-1:0]            sum_o,
  output logic                        out_valid_o
);
  opvec_t ops;
  sum_t   tree_sum;
  assign ops = opvec_t'(operands_i);

  csa7_tree u_tree (
    .operands(ops),
    .total   (tree_sum)
  );

  if (REG_OUT) begin : g_reg
    sum_t sum_q;
    logic vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sum_q <= '0;
        vld_q <= 1'b0;
      end else begin
        sum_q <= tree_sum;
        vld_q <= in_valid_i;
      end
    end

    assign sum_o       = sum_q;
    assign out_valid_o = vld_q;

    sum_t             ref_now;
    logic [N_OPS-1:0] lsb_col;
    always_comb begin
      ref_now = ref_total(ops);
      for (int k = 0; k < N_OPS; k++) lsb_col[k] = ops[k][0];
    end

    p_sum_exact_r1: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sum_o == $past(ref_now)));
    p_lsb_parity_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (sum_o[0] == ^$past(lsb_col)));
    p_valid_delay_r8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_valid_o == $past(in_valid_i)));
    p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (sum_o == '0 && !out_valid_o));
  end else begin : g_comb
    assign sum_o       = tree_sum;
    assign out_valid_o = in_valid_i;
  end
endmodule

// File: tb/csa7_adder_bench.sv
module csa7_adder_bench;
  import csa7_pkg::*;

  logic   clk = 1'b0;
  logic   rst = 1'b1;
  logic   in_vld = 1'b0;
  opvec_t ops = '0;
  sum_t   sum_r, sum_c;
  logic   vld_r, vld_c;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  csa7_adder #(.REG_OUT(1'b1)) u_csa7_adder (
    .clk(clk), .rst(rst), .in_valid_i(in_vld), .operands_i(ops),
    .sum_o(sum_r), .out_valid_o(vld_r)
  );

  csa7_adder #(.REG_OUT(1'b0)) u_csa7_adder_comb (
    .clk(clk), .rst(rst), .in_valid_i(in_vld), .operands_i(ops),
    .sum_o(sum_c), .out_valid_o(vld_c)
  );

  localparam int NV = 9;
  localparam opvec_t VOPS [NV] = '{
    {6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0 },
    {6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63, 6'd63},
    {6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  6'd1 },
    {6'd1,  6'd1,  6'd1,  6'd1,  6'd1,  6'd1,  6'd1 },
    {6'd32, 6'd32, 6'd32, 6'd32, 6'd32, 6'd32, 6'd32},
    {6'd0,  6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63},
    {6'd0,  6'd0,  6'd63, 6'd63, 6'd63, 6'd63, 6'd63},
    {6'd3,  6'd34, 6'd17, 6'd40, 6'd20, 6'd10, 6'd5 },
    {6'd42, 6'd21, 6'd42, 6'd21, 6'd42, 6'd21, 6'd42}
  };
  localparam int VEXP [NV] = '{0, 441, 1, 7, 224, 252, 315, 129, 231};

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input opvec_t v, input logic vld, input int exp, input string tag);
    @(negedge clk);
    ops    = v;
    in_vld = vld;
    #1;
    check({tag, " comb R10"}, int'(sum_c), exp);
    check("R10 comb valid", int'(vld_c), int'(vld));
    @(negedge clk);
    check({tag, " reg R7"}, int'(sum_r), exp);
    check("R8 reg valid", int'(vld_r), int'(vld));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    opvec_t v;
    int     exp, prev_exp;
    logic   prev_vld;

    // reset with busy inputs: R9
    ops    = {N_OPS{6'd63}};
    in_vld = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset sum", int'(sum_r), 0);
    check("R9 reset valid", int'(vld_r), 0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      apply(VOPS[i], i[0], VEXP[i], "R1 R2 R3 R4 table");
      check("R6 top bit", int'(sum_r[SUM_W-1]), int'(VEXP[i] >= 256));
      check("R5 lsb parity", int'(sum_r[0]), VEXP[i] % 2);
    end

    // random vectors: R1 R5
    for (int n = 0; n < 10000; n++) begin
      logic [N_OPS-1:0] lsbs;
      exp = 0;
      for (int k = 0; k < N_OPS; k++) begin
        v[k]    = OP_W'($urandom_range(0, 63));
        exp     = exp + int'(v[k]);
        lsbs[k] = v[k][0];
      end
      apply(v, n[1], exp, "R1 random");
      check("R5 random lsb", int'(sum_r[0]), int'(^lsbs));
    end

    // back-to-back stream: R7 R8
    prev_exp = 0;
    prev_vld = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check("R7 stream sum", int'(sum_r), prev_exp);
        check("R8 stream valid", int'(vld_r), int'(prev_vld));
      end
      exp = 0;
      for (int k = 0; k < N_OPS; k++) begin
        v[k] = OP_W'($urandom_range(0, 63));
        exp  = exp + int'(v[k]);
      end
      ops      = v;
      in_vld   = i[0] ^ i[2];
      prev_exp = exp;
      prev_vld = in_vld;
    end

    // mid-run reset held for two edges: R9
    @(negedge clk);
    ops    = {N_OPS{6'd63}};
    in_vld = 1'b1;
    rst    = 1'b1;
    @(negedge clk);
    check("R9 mid reset sum", int'(sum_r), 0);
    check("R9 mid reset valid", int'(vld_r), 0);
    @(negedge clk);
    check("R9 reset held", int'(sum_r), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 after reset", int'(sum_r), 441);
    check("R8 after reset", int'(vld_r), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule